// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block sits on the host side of a serial NOR flash. It performs one erase on request. A single-cycle start pulse, together with an erase size (small subsector or large sector) and a target address, sets it going. The sequencer runs a SPI mode 0 master with a chip select, a serial clock, a data-out line and a data-in line. The serial clock is derived from the system clock by a parameterised divider.

An erase runs as up to four chip-select frames:

1. A one-byte write-enable frame.
2. The erase frame. It carries the erase opcode followed by the address bytes, most significant first. Chip select rises at the byte boundary that ends the last address bit.
3. A status poll frame. After a read-flag-status opcode, chip select stays low and status bytes are read back to back until one arrives with its ready bit set. A host watchdog marks the operation as hung if the poll runs too long, but the poll keeps going until ready appears.
4. A one-byte clear-flag-status frame, sent only if any error was found.

When the sequence ends, the block raises done for one cycle. Three error flags (erase failure, protected target, watchdog hang) stay valid until the next start.

Top module: `flash_erase_seq`

## Requirements
- R1: During and after reset, chip select is high, the serial clock is low, and done, busy and all three error flags are low.
- R2: After an accepted start, the first frame on the bus is exactly one byte, 06h, and chip select goes high after that byte before any other byte is sent.
- R3: The serial clock idles low and is only toggled while chip select is low. Data out is sent most significant bit first and does not change while the clock is high. Each clock high phase lasts HALF_DIV system clocks. Chip select only changes while the clock is low.
- R4: The second frame carries the opcode 20h when the erase size input is 0, or D8h when it is 1. It is followed by ADDR_BYTES address bytes, most significant byte first, with exactly 8*(1+ADDR_BYTES) clock pulses in the frame.
- R5: The third frame starts with opcode 70h. It then holds chip select low and reads status bytes until the first byte whose bit 7 is 1, and that byte is the last one in the frame.
- R6: From the final status byte, bit 5 and bit 1 both set reports a protected target. Bit 5 set with bit 1 clear reports an erase failure. Bit 1 alone, or neither bit, reports no flag error.
- R7: If the poll frame lasts longer than WD_LIMIT system clocks, the hang flag is reported. Polling still continues until a ready byte is read.
- R8: If any error flag is to be reported, a one-byte frame 50h follows the poll frame before done. With no error, no fourth frame is sent.
- R9: Done is high for exactly one cycle. Busy is high from the cycle after an accepted start until done. The error flags are zero while busy and hold their values after done until the next accepted start.
- R10: A start pulse that arrives while an erase is in progress is ignored. It changes neither the frames nor the address sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Single-cycle request to begin an erase |
| eraseSector | input | 1 | Erase size: 0 subsector, 1 sector |
| eraseAddr | input | 8*ADDR_BYTES | Any address inside the target region |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSclk | output | 1 | Serial clock, mode 0 |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| donePulse | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Erase sequence in progress |
| errErase | output | 1 | Erase failure reported by the flash |
| errProtect | output | 1 | Target region was protected |
| errHang | output | 1 | Ready took longer than the watchdog limit |

## Verification
The bench builds the block with HALF_DIV=2, ADDR_BYTES=3, CS_GAP=3 and WD_LIMIT=200. With a four-clock bit period, a status byte takes 32 cycles. A flash model that answers busy for twenty bytes therefore carries the poll well past the watchdog limit, while two busy bytes stay well under it. The same short clock keeps every scenario within a few hundred cycles, so the model can run both erase sizes, each error pattern, the bit-1-alone case and a start issued mid-operation.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_SUBERS  = 8'h20;
  localparam logic [7:0] OP_SECERS  = 8'hD8;
  localparam logic [7:0] OP_RDFLAG  = 8'h70;
  localparam logic [7:0] OP_CLRFLAG = 8'h50;
  localparam logic [7:0] OP_FILL    = 8'h00;

  localparam int RDY_BIT  = 7;
  localparam int ERS_BIT  = 5;
  localparam int PROT_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       csLow;
    logic       csHigh;
    logic       load;
    logic [7:0] txByte;
    logic       addrShift;
    logic       gapStart;
    logic       wdClear;
    logic       wdRun;
  } dpCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_WREN_GAP,
    ST_ERS_OPC,
    ST_ERS_ADDR,
    ST_ERS_GAP,
    ST_POLL_OPC,
    ST_POLL_RD,
    ST_POLL_GAP,
    ST_CLR,
    ST_CLR_GAP,
    ST_DONE
  } seqState_t;

endpackage

// File: rtl/fes_datapath.sv
module fes_datapath
  import fes_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int ADDR_BYTES = 3,
  parameter int CS_GAP     = 4,
  parameter int WD_LIMIT   = 1000000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [8*ADDR_BYTES-1:0] startAddr,
  input  logic                    spiMiso,
  output logic                    spiCsN,
  output logic                    spiSclk,
  output logic                    spiMosi,
  output logic                    byteDone,
  output logic                    flagRdy,
  output logic                    flagErs,
  output logic                    flagProt,
  output logic [7:0]              addrTop,
  output logic                    gapDone,
  output logic                    wdTrip
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int WD_W   = $clog2(WD_LIMIT + 1);

  logic              active;
  logic              tick;
  logic [2:0]        bitCnt;
  logic [7:0]        txShift;
  logic [7:0]        rxShift;
  logic [ADDR_W-1:0] addrReg;
  logic [GAP_W-1:0]  gapCnt;
  logic              gapBusy;
  logic [WD_W-1:0]   wdCnt;

  // half-period tick generator
  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign tick = active;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (!active || ctl.load) begin
          divCnt <= '0;
        end else if (divCnt == DIV_W'(HALF_DIV - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign tick = active && (divCnt == DIV_W'(HALF_DIV - 1));
    end
  endgenerate

  // byte shifter, mode 0: sample on rise, shift on fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      bitCnt   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      spiSclk  <= 1'b0;
      byteDone <= 1'b0;
      flagRdy  <= 1'b0;
      flagErs  <= 1'b0;
      flagProt <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.load) begin
        txShift <= ctl.txByte;
        active  <= 1'b1;
        bitCnt  <= '0;
        spiSclk <= 1'b0;
      end else if (tick) begin
        if (!spiSclk) begin
          spiSclk <= 1'b1;
          rxShift <= {rxShift[6:0], spiMiso};
        end else begin
          spiSclk <= 1'b0;
          if (bitCnt == 3'd7) begin
            active   <= 1'b0;
            byteDone <= 1'b1;
            flagRdy  <= rxShift[RDY_BIT];
            flagErs  <= rxShift[ERS_BIT];
            flagProt <= rxShift[PROT_BIT];
          end else begin
            bitCnt  <= bitCnt + 1'b1;
            txShift <= {txShift[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign spiMosi = txShift[7];

  // chip select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiCsN <= 1'b1;
    end else if (ctl.csLow) begin
      spiCsN <= 1'b0;
    end else if (ctl.csHigh) begin
      spiCsN <= 1'b1;
    end
  end

  // address byte feeder
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctl.capture) begin
      addrReg <= startAddr;
    end else if (ctl.addrShift) begin
      addrReg <= addrReg << 8;
    end
  end

  assign addrTop = addrReg[ADDR_W-1 -: 8];

  // chip-select high gap timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt  <= '0;
      gapBusy <= 1'b0;
      gapDone <= 1'b0;
    end else begin
      gapDone <= 1'b0;
      if (ctl.gapStart) begin
        gapCnt  <= GAP_W'(CS_GAP - 1);
        gapBusy <= 1'b1;
      end else if (gapBusy) begin
        if (gapCnt == '0) begin
          gapBusy <= 1'b0;
          gapDone <= 1'b1;
        end else begin
          gapCnt <= gapCnt - 1'b1;
        end
      end
    end
  end

  // poll watchdog, sticky until cleared
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt  <= '0;
      wdTrip <= 1'b0;
    end else if (ctl.wdClear) begin
      wdCnt  <= '0;
      wdTrip <= 1'b0;
    end else if (ctl.wdRun && !wdTrip) begin
      if (wdCnt == WD_W'(WD_LIMIT - 1)) begin
        wdTrip <= 1'b1;
      end else begin
        wdCnt <= wdCnt + 1'b1;
      end
    end
  end

  AST_CS_EDGE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN != $past(spiCsN)) |-> !spiSclk);  // R3
  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> !spiCsN);  // R3
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(spiSclk) && spiSclk) |-> $stable(spiMosi));  // R3
  AST_BYTE_END_LOW: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> !spiSclk);  // R4

endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       eraseSector,
  input  logic       byteDone,
  input  logic       flagRdy,
  input  logic       flagErs,
  input  logic       flagProt,
  input  logic [7:0] addrTop,
  input  logic       gapDone,
  input  logic       wdTrip,
  output dpCtl_t     ctl,
  output logic       donePulse,
  output logic       busy,
  output logic       errErase,
  output logic       errProtect,
  output logic       errHang
);

  localparam int IDX_W = $clog2(ADDR_BYTES) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  seqState_t        state, nextState;
  logic [IDX_W-1:0] idx;
  logic             idxInc, idxClr, latchFlags;
  logic             sectorReg;
  logic             pendErs, pendProt, pendHang;
  logic             needClear;

  assign needClear = pendErs | pendProt | pendHang;

  always_comb begin
    nextState  = state;
    ctl        = '0;
    idxInc     = 1'b0;
    idxClr     = 1'b0;
    latchFlags = 1'b0;
    unique case (state)
      ST_IDLE: if (startPulse) begin
        ctl.capture = 1'b1;
        ctl.csLow   = 1'b1;
        ctl.load    = 1'b1;
        ctl.txByte  = OP_WREN;
        nextState   = ST_WREN;
      end
      ST_WREN: if (byteDone) begin
        ctl.csHigh   = 1'b1;
        ctl.gapStart = 1'b1;
        nextState    = ST_WREN_GAP;
      end
      ST_WREN_GAP: if (gapDone) begin
        ctl.csLow  = 1'b1;
        ctl.load   = 1'b1;
        ctl.txByte = sectorReg ? OP_SECERS : OP_SUBERS;
        nextState  = ST_ERS_OPC;
      end
      ST_ERS_OPC: if (byteDone) begin
        ctl.load      = 1'b1;
        ctl.txByte    = addrTop;
        ctl.addrShift = 1'b1;
        idxClr        = 1'b1;
        nextState     = ST_ERS_ADDR;
      end
      ST_ERS_ADDR: if (byteDone) begin
        if (idx == LAST_IDX) begin
          ctl.csHigh   = 1'b1;
          ctl.gapStart = 1'b1;
          nextState    = ST_ERS_GAP;
        end else begin
          ctl.load      = 1'b1;
          ctl.txByte    = addrTop;
          ctl.addrShift = 1'b1;
          idxInc        = 1'b1;
        end
      end
      ST_ERS_GAP: if (gapDone) begin
        ctl.csLow   = 1'b1;
        ctl.load    = 1'b1;
        ctl.txByte  = OP_RDFLAG;
        ctl.wdClear = 1'b1;
        nextState   = ST_POLL_OPC;
      end
      ST_POLL_OPC: begin
        ctl.wdRun = 1'b1;
        if (byteDone) begin
          ctl.load   = 1'b1;
          ctl.txByte = OP_FILL;
          nextState  = ST_POLL_RD;
        end
      end
      ST_POLL_RD: begin
        ctl.wdRun = 1'b1;
        if (byteDone) begin
          if (flagRdy) begin
            latchFlags   = 1'b1;
            ctl.csHigh   = 1'b1;
            ctl.gapStart = 1'b1;
            nextState    = ST_POLL_GAP;
          end else begin
            ctl.load   = 1'b1;
            ctl.txByte = OP_FILL;
          end
        end
      end
      ST_POLL_GAP: if (gapDone) begin
        if (needClear) begin
          ctl.csLow  = 1'b1;
          ctl.load   = 1'b1;
          ctl.txByte = OP_CLRFLAG;
          nextState  = ST_CLR;
        end else begin
          nextState = ST_DONE;
        end
      end
      ST_CLR: if (byteDone) begin
        ctl.csHigh   = 1'b1;
        ctl.gapStart = 1'b1;
        nextState    = ST_CLR_GAP;
      end
      ST_CLR_GAP: if (gapDone) nextState = ST_DONE;
      ST_DONE:    nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idx        <= '0;
      sectorReg  <= 1'b0;
      pendErs    <= 1'b0;
      pendProt   <= 1'b0;
      pendHang   <= 1'b0;
      errErase   <= 1'b0;
      errProtect <= 1'b0;
      errHang    <= 1'b0;
    end else begin
      state <= nextState;
      if (idxClr)      idx <= '0;
      else if (idxInc) idx <= idx + 1'b1;
      if (ctl.capture) begin
        sectorReg  <= eraseSector;
        pendErs    <= 1'b0;
        pendProt   <= 1'b0;
        pendHang   <= 1'b0;
        errErase   <= 1'b0;
        errProtect <= 1'b0;
        errHang    <= 1'b0;
      end
      if (latchFlags) begin
        pendProt <= flagErs & flagProt;
        pendErs  <= flagErs & ~flagProt;
        pendHang <= wdTrip;
      end
      if (state != ST_DONE && nextState == ST_DONE) begin
        errErase   <= pendErs;
        errProtect <= pendProt;
        errHang    <= pendHang;
      end
    end
  end

  assign donePulse = (state == ST_DONE);
  assign busy      = (state != ST_IDLE) && (state != ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);  // R9
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(errErase || errProtect || errHang));  // R9
  AST_CLEAR_BEFORE_ERR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && needClear) |-> ($past(state) == ST_CLR_GAP));  // R8
  AST_NO_CLEAR_WHEN_OK: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && !needClear) |-> ($past(state) == ST_POLL_GAP));  // R8
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(errErase && errProtect));  // R6

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int ADDR_BYTES = 3,
  parameter int CS_GAP     = 4,
  parameter int WD_LIMIT   = 1000000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  input  logic                    eraseSector,
  input  logic [8*ADDR_BYTES-1:0] eraseAddr,
  output logic                    spiCsN,
  output logic                    spiSclk,
  output logic                    spiMosi,
  input  logic                    spiMiso,
  output logic                    donePulse,
  output logic                    busy,
  output logic                    errErase,
  output logic                    errProtect,
  output logic                    errHang
);

  dpCtl_t     ctl;
  logic       byteDone, flagRdy, flagErs, flagProt, gapDone, wdTrip;
  logic [7:0] addrTop;

  fes_ctrl #(
    .ADDR_BYTES(ADDR_BYTES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .eraseSector(eraseSector),
    .byteDone   (byteDone),
    .flagRdy    (flagRdy),
    .flagErs    (flagErs),
    .flagProt   (flagProt),
    .addrTop    (addrTop),
    .gapDone    (gapDone),
    .wdTrip     (wdTrip),
    .ctl        (ctl),
    .donePulse  (donePulse),
    .busy       (busy),
    .errErase   (errErase),
    .errProtect (errProtect),
    .errHang    (errHang)
  );

  fes_datapath #(
    .HALF_DIV  (HALF_DIV),
    .ADDR_BYTES(ADDR_BYTES),
    .CS_GAP    (CS_GAP),
    .WD_LIMIT  (WD_LIMIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startAddr(eraseAddr),
    .spiMiso  (spiMiso),
    .spiCsN   (spiCsN),
    .spiSclk  (spiSclk),
    .spiMosi  (spiMosi),
    .byteDone (byteDone),
    .flagRdy  (flagRdy),
    .flagErs  (flagErs),
    .flagProt (flagProt),
    .addrTop  (addrTop),
    .gapDone  (gapDone),
    .wdTrip   (wdTrip)
  );

endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;

  localparam int HALF_DIV   = 2;
  localparam int ADDR_BYTES = 3;
  localparam int CS_GAP     = 3;
  localparam int WD_LIMIT   = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        eraseSector = 1'b0;
  logic [23:0] eraseAddr = '0;
  logic        spiCsN, spiSclk, spiMosi, spiMiso;
  logic        donePulse, busy, errErase, errProtect, errHang;

  int nChecks = 0;
  int nBad = 0;

  always #4 clk = ~clk;  // 125 MHz

  flash_erase_seq #(
    .HALF_DIV(HALF_DIV), .ADDR_BYTES(ADDR_BYTES),
    .CS_GAP(CS_GAP), .WD_LIMIT(WD_LIMIT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .eraseSector(eraseSector), .eraseAddr(eraseAddr),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .donePulse(donePulse), .busy(busy), .errErase(errErase),
    .errProtect(errProtect), .errHang(errHang)
  );

  // ---------------- flash model ----------------
  int         bitCnt = 0;
  logic [7:0] shiftIn = '0;
  logic [7:0] curOp = '0;
  int         frameCnt = 0;
  logic [7:0] fOp [8];
  int         fLen [8];
  logic [7:0] fAddr [8][4];
  bit         fAlign [8];
  int         busyReads = 0;
  logic [7:0] readyVal = 8'h80;

  always @(negedge spiCsN) bitCnt = 0;

  always @(posedge spiSclk) begin
    if (!spiCsN) begin
      shiftIn = {shiftIn[6:0], spiMosi};
      bitCnt++;
      if (bitCnt % 8 == 0) begin
        if (bitCnt / 8 == 1) curOp = shiftIn;
        if (frameCnt < 8) begin
          if (bitCnt / 8 == 1) fOp[frameCnt] = shiftIn;
          else if (bitCnt / 8 <= 4) fAddr[frameCnt][bitCnt / 8 - 1] = shiftIn;
        end
      end
    end
  end

  always @(posedge spiCsN) begin
    if (frameCnt < 8) begin
      fLen[frameCnt]   = bitCnt / 8;
      fAlign[frameCnt] = (bitCnt % 8 == 0);
    end
    frameCnt++;
  end

  function automatic logic [7:0] statusFor(input int k);
    return (k > busyReads) ? readyVal : 8'h00;
  endfunction

  always_comb begin
    logic [7:0] sb;
    sb = statusFor(bitCnt / 8);
    if (curOp == 8'h70 && (bitCnt / 8) >= 1) spiMiso = sb[7 - (bitCnt % 8)];
    else spiMiso = 1'b0;
  end

  // ---------------- bus timing monitor ----------------
  int   hiRun = 0;
  logic prevMosi = 1'b0;
  int   mosiBad = 0;
  int   sclkBad = 0;
  int   sclkNoCs = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (spiSclk) begin
        if (spiCsN) sclkNoCs++;
        if (hiRun > 0 && spiMosi !== prevMosi) mosiBad++;
        hiRun++;
      end else begin
        if (hiRun != 0 && hiRun != HALF_DIV) sclkBad++;
        hiRun = 0;
      end
      prevMosi = spiMosi;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 csN in reset", {31'd0, spiCsN}, 1);
    chk("R1 sclk in reset", {31'd0, spiSclk}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 csN after reset", {31'd0, spiCsN}, 1);
    chk("R1 sclk after reset", {31'd0, spiSclk}, 0);
    chk("R1 done/busy after reset", {30'd0, donePulse, busy}, 0);
    chk("R1 errors after reset", {29'd0, errErase, errProtect, errHang}, 0);
  endtask

  task automatic runErase(input string name, input bit sect, input logic [23:0] a,
                          input int nBusy, input logic [7:0] rv,
                          input bit expE, input bit expP, input bit expH,
                          input bit pokeStart);
    int n;
    bit anyErr;
    anyErr = expE | expP | expH;
    busyReads = nBusy;
    readyVal = rv;
    frameCnt = 0;
    @(negedge clk);
    eraseSector = sect;
    eraseAddr = a;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk({"R9 busy after start ", name}, {31'd0, busy}, 1);
    chk({"R9 errors cleared at start ", name}, {29'd0, errErase, errProtect, errHang}, 0);
    if (pokeStart) begin
      repeat (40) @(negedge clk);
      eraseSector = ~sect;
      eraseAddr = ~a;
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    n = 0;
    while (!donePulse && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk({"R9 done seen ", name}, {31'd0, donePulse}, 1);
    chk({"R6 erase flag ", name}, {31'd0, errErase}, {31'd0, expE});
    chk({"R6 protect flag ", name}, {31'd0, errProtect}, {31'd0, expP});
    chk({"R7 hang flag ", name}, {31'd0, errHang}, {31'd0, expH});
    @(negedge clk);
    chk({"R9 done one cycle ", name}, {30'd0, donePulse, busy}, 0);
    repeat (5) @(negedge clk);
    chk({"R9 flags held ", name}, {29'd0, errErase, errProtect, errHang},
        {29'd0, expE, expP, expH});
    chk({"R8 frame count ", name}, frameCnt, anyErr ? 4 : 3);
    chk({"R10 no extra frames ", name}, frameCnt, anyErr ? 4 : 3);
    chk({"R2 wren opcode ", name}, {24'd0, fOp[0]}, 32'h06);
    chk({"R2 wren own frame ", name}, fLen[0], 1);
    chk({"R4 erase opcode ", name}, {24'd0, fOp[1]}, sect ? 32'hD8 : 32'h20);
    chk({"R4 erase frame length ", name}, fLen[1], 1 + ADDR_BYTES);
    chk({"R4 address bytes ", name}, {8'd0, fAddr[1][1], fAddr[1][2], fAddr[1][3]}, {8'd0, a});
    chk({"R4 byte aligned frames ", name},
        {28'd0, fAlign[0], fAlign[1], fAlign[2], anyErr ? fAlign[3] : 1'b1}, 32'hF);
    chk({"R5 poll opcode ", name}, {24'd0, fOp[2]}, 32'h70);
    chk({"R5 poll length ", name}, fLen[2], nBusy + 2);
    if (anyErr) begin
      chk({"R8 clear opcode ", name}, {24'd0, fOp[3]}, 32'h50);
      chk({"R8 clear frame length ", name}, fLen[3], 1);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    runErase("subsector ok",  1'b0, 24'h12_34_56, 2, 8'h80, 0, 0, 0, 0);
    runErase("sector fail",   1'b1, 24'hA5_0F_C3, 1, 8'hA0, 1, 0, 0, 0);
    runErase("protected",     1'b0, 24'h00_FF_01, 0, 8'hA2, 0, 1, 0, 0);
    runErase("bit1 only",     1'b1, 24'h7E_81_18, 3, 8'h82, 0, 0, 0, 0);
    runErase("hang",          1'b0, 24'h3C_3C_3C, 20, 8'h80, 0, 0, 1, 0);
    runErase("restart ignored", 1'b1, 24'h5A_69_96, 4, 8'h80, 0, 0, 0, 1);
    chk("R3 mosi stable while sclk high", mosiBad, 0);
    chk("R3 sclk high width", sclkBad, 0);
    chk("R3 sclk only with cs low", sclkNoCs, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule